// File: doc/BRIEF.md
# Packed 12-bit Grayscale Serial Shifter

This block keeps the grayscale levels for a chain of LED driver chips. Each chip has 16 channels, and each channel holds a 12-bit level. The block stores the levels already packed in the order in which they travel on the wire. A controller writes single channels through an index, data and write-enable port. Writes can arrive at any time.

When the frame sequencer pulses `start`, the block takes a snapshot of the whole packed frame. It then sends the snapshot over a one-way serial link made of a clock and a data line. The serial clock comes from a divider whose half period is set per frame. The data line changes only on falling clock edges, so the receiving chips see a stable bit at every rising edge. After the last bit, a one-cycle `done` pulse tells the sequencer that the chips now hold a complete frame and need a latch strobe. The block does not choose when frames happen or when the latch fires.

Top module: `gs_frame_shifter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `busy`, `done`, `sclk` and `mosi` are all 0. After reset every stored channel level reads as 0.
- R2: One frame gives exactly NUM_CHIPS×192 rising edges of `sclk`, which is 24 bytes per chip.
- R3: Bit k of a frame (k counted from 0 at the first rising edge) is bit 11−(k mod 12) of channel NUM_CHIPS×16−1−⌊k/12⌋. The highest channel goes first and channel 0 goes last, each channel most significant bit first.
- R4: Packing depends on the channel index. An odd index puts bits 11..4 in one whole byte and bits 3..0 in the upper nibble of the byte after it. An even index puts bits 11..8 in the lower nibble of a byte and bits 7..0 in the whole byte after it. A write changes only its own channel; the neighbour that shares a byte keeps its nibble.
- R5: A write whose `wr_idx` is NUM_CHIPS×16 or more changes nothing.
- R6: Each half period of `sclk` lasts `div_cfg`+1 clock cycles, using the value sampled with the accepted `start`. `sclk` idles low and its first half period in a frame is low. `mosi` changes only on a falling edge of `sclk` or on the launch cycle. Bytes follow each other with no gap, so `done` rises exactly 2×(`div_cfg`+1)×NUM_CHIPS×192 cycles after the launch edge.
- R7: `done` is high for exactly one cycle. That cycle is the one in which `busy` falls, together with the final falling edge of `sclk`.
- R8: A `start` seen while idle launches a frame on the next edge. A `start` seen while `busy` is high is ignored, and the running frame keeps its length and content.
- R9: A write that lands during a frame does not change any bit of that frame. The write is kept and appears in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_cfg | input | DIV_W | Serial clock half period minus one, in `clk` cycles |
| start | input | 1 | Request to send the stored frame |
| wr_en | input | 1 | Channel write strobe |
| wr_idx | input | IDX_W | Channel index of the write |
| wr_data | input | 12 | Grayscale level to store |
| busy | output | 1 | A frame is being shifted |
| done | output | 1 | One-cycle pulse after the last bit |
| sclk | output | 1 | Serial clock to the chip chain |
| mosi | output | 1 | Serial data to the chip chain |

## Verification
The stream is captured at each rising edge of `sclk` and compared with an arithmetic model of the expected frame. The frames tried are:
- an all-zero frame;
- a frame where every channel carries a value computed from its index, which shows any misordering of channels or bits;
- a sweep that inverts one channel at a time over that pattern, through every odd and every even index, which separates a correct nibble merge from one that clobbers the neighbour;
- a frame after writes to every out-of-range index.

Divider settings of 0, 1, 3 and 5 check the half period and confirm there is no gap between bytes, through the exact start-to-done cycle count. Frames disturbed by a second `start`, or by a write to a channel already sent and to one not yet sent, show that neither a restart nor a live patch reaches the wire.

// File: rtl/gsf_pkg.sv
`timescale 1ns/1ps
// Shared constants for the grayscale frame shifter.
// Assumes the chain geometry is fixed: 16 channels of 12 bits per chip.
package gsf_pkg;
    localparam int CH_PER_CHIP    = 16;
    localparam int GS_W           = 12;
    localparam int BITS_PER_CHIP  = CH_PER_CHIP * GS_W;
    localparam int BYTES_PER_CHIP = BITS_PER_CHIP / 8;
endpackage

// File: rtl/gsf_store.sv
`timescale 1ns/1ps
// Packed frame store. It holds every channel level in wire order. Byte 0
// is sent first, and within a byte bit 7 goes first. Channel writes are
// merged nibble by nibble, so the channel that shares a byte is kept.
// Assumes an even channel count, which holds for 16 channels per chip.
module gsf_store
    import gsf_pkg::*;
#(
    parameter int NUM_CHIPS = 2,
    parameter int IDX_W     = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [GS_W-1:0]       wr_data,
    output logic [NUM_CHIPS*BITS_PER_CHIP-1:0] frame_flat
);
    localparam int NCH    = NUM_CHIPS * CH_PER_CHIP;
    localparam int NBYTES = NUM_CHIPS * BYTES_PER_CHIP;
    localparam int NBITS  = NBYTES * 8;
    localparam int BI_W   = $clog2(NBYTES) + 2;
    localparam logic [IDX_W-1:0] NCH_V = IDX_W'(NCH);

    logic            wr_ok;
    logic            odd_ch;
    logic [IDX_W-1:0] pos;
    logic [BI_W-1:0]  pos_ext;
    logic [BI_W-1:0]  di;
    logic [BI_W-1:0]  di_next;

    // Decode the write: range check, parity, and the first byte it touches.
    always_comb begin
        wr_ok   = wr_en && (wr_idx < NCH_V);
        odd_ch  = wr_idx[0];
        pos     = NCH_V - IDX_W'(1) - wr_idx;
        pos_ext = BI_W'(pos);
        di      = (pos_ext + (pos_ext << 1)) >> 1;
        di_next = di + BI_W'(1);
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [3:0] hi_q;
        logic [3:0] lo_q;
        logic       hit_first;
        logic       hit_second;

        assign hit_first  = wr_ok && (di == BI_W'(b));
        assign hit_second = wr_ok && (di_next == BI_W'(b));

        // Merge the written nibbles into this byte; untouched nibbles hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q <= '0;
                lo_q <= '0;
            end else if (hit_first && odd_ch) begin
                hi_q <= wr_data[11:8];
                lo_q <= wr_data[7:4];
            end else if (hit_first) begin
                lo_q <= wr_data[11:8];
            end else if (hit_second && odd_ch) begin
                hi_q <= wr_data[3:0];
            end else if (hit_second) begin
                hi_q <= wr_data[7:4];
                lo_q <= wr_data[3:0];
            end
        end

        assign frame_flat[NBITS-1-8*b -: 8] = {hi_q, lo_q};
    end
endmodule

// File: rtl/gsf_clkdiv.sv
`timescale 1ns/1ps
// Serial clock generator. It latches the half period at launch and
// toggles sclk every div+1 cycles while a frame runs. It flags the cycle
// in which sclk falls, so the shifter can move to the next bit.
// Assumes load and run are never high in the same cycle.
module gsf_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             sclk,
    output logic             fall_tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic             half_end;

    // A half period ends when the counter reaches the latched divider.
    assign half_end  = run && (cnt_q == div_q);
    assign fall_tick = half_end && sclk_q;
    assign sclk      = sclk_q;

    // Count half periods and toggle the serial clock; idle low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (load) begin
            div_q  <= div_in;
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end else if (half_end) begin
            cnt_q  <= '0;
            sclk_q <= !sclk_q;
        end else if (run) begin
            cnt_q  <= cnt_q + DIV_W'(1);
        end else begin
            cnt_q  <= '0;
            sclk_q <= 1'b0;
        end
    end
endmodule

// File: rtl/gsf_shifter.sv
`timescale 1ns/1ps
// Frame shifter. On an accepted start it copies the packed frame into a
// shift register and presents its top bit on mosi. It advances one bit on
// each falling sclk edge, and pulses done after the last bit.
// Assumes fall_tick comes from a divider that was loaded by launch.
module gsf_shifter
    import gsf_pkg::*;
#(
    parameter int NBITS = 384
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fall_tick,
    input  logic [NBITS-1:0] frame_in,
    output logic             launch,
    output logic             busy,
    output logic             mosi,
    output logic             done
);
    localparam int CNT_W = $clog2(NBITS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);

    typedef enum logic {ST_IDLE, ST_SHIFT} shift_state_e;

    shift_state_e     state_q;
    logic [NBITS-1:0] sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Only an idle shifter accepts a start.
    assign launch = start && (state_q == ST_IDLE);
    assign busy   = (state_q == ST_SHIFT);
    assign mosi   = busy && sh_q[NBITS-1];
    assign done   = done_q;

    // Snapshot, shift on falling edges, and close the frame after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (launch) begin
                state_q <= ST_SHIFT;
                sh_q    <= frame_in;
                cnt_q   <= '0;
            end else if (busy && fall_tick) begin
                if (cnt_q == LAST) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    sh_q  <= sh_q << 1;
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/gs_frame_shifter.sv
`timescale 1ns/1ps
// Top level of the grayscale frame shifter. It ties the packed store,
// the serial clock divider and the frame shifter together.
// Assumes the sequencer waits for done before it strobes the chip latch.
module gs_frame_shifter
    import gsf_pkg::*;
#(
    parameter int NUM_CHIPS = 2,
    parameter int DIV_W     = 8,
    parameter int IDX_W     = $clog2(NUM_CHIPS * CH_PER_CHIP) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic             start,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [11:0]      wr_data,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             mosi
);
    localparam int NBITS = NUM_CHIPS * BITS_PER_CHIP;

    logic [NBITS-1:0] frame_flat;
    logic             launch;
    logic             fall_tick;

    gsf_store #(
        .NUM_CHIPS (NUM_CHIPS),
        .IDX_W     (IDX_W)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .frame_flat (frame_flat)
    );

    gsf_clkdiv #(
        .DIV_W (DIV_W)
    ) i_clkdiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (launch),
        .run       (busy),
        .div_in    (div_cfg),
        .sclk      (sclk),
        .fall_tick (fall_tick)
    );

    gsf_shifter #(
        .NBITS (NBITS)
    ) i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .fall_tick (fall_tick),
        .frame_in  (frame_flat),
        .launch    (launch),
        .busy      (busy),
        .mosi      (mosi),
        .done      (done)
    );
endmodule

// File: rtl/gsf_checker.sv
`timescale 1ns/1ps
// Protocol checker for the grayscale frame shifter, bound to the top.
// Assumes the reset is held low over the first clock edge.
module gsf_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic sclk,
    input logic mosi
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !sclk && !mosi)); // R1

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk); // R6

    AST_MOSI_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi)); // R6

    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$fell(sclk)) |-> $stable(mosi)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_CLOSES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy) && $fell(sclk))); // R7

    AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !sclk)); // R8
endmodule

bind gs_frame_shifter gsf_checker i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .sclk  (sclk),
    .mosi  (mosi)
);

// File: tb/test_gs_frame_shifter.sv
`timescale 1ns/1ps
module test_gs_frame_shifter;
    localparam int NUM_CHIPS = 2;
    localparam int DIV_W     = 8;
    localparam int NCH       = NUM_CHIPS * 16;
    localparam int NB        = NUM_CHIPS * 192;
    localparam int IDX_W     = $clog2(NCH) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_cfg = '0;
    logic             start = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [11:0]      wr_data = '0;
    logic             busy, done, sclk, mosi;

    int n_chk = 0;
    int n_fail = 0;
    logic [11:0] model [NCH];
    logic [11:0] snap  [NCH];
    logic        gotv  [NB];

    always #2.5 clk = ~clk;

    gs_frame_shifter #(.NUM_CHIPS(NUM_CHIPS), .DIV_W(DIV_W)) i_gs_frame_shifter (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .start(start),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .busy(busy), .done(done), .sclk(sclk), .mosi(mosi)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_ch(input int idx, input logic [11:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (idx < NCH) model[idx] = data;
    endtask

    // Run one frame; optional second start at cycle 40, optional write at cycle 60.
    task automatic run_frame(input int div, input string req, input bit mid_start,
                             input bit mid_wr, input int mid_idx, input logic [11:0] mid_data);
        int cyc, edges, bad, limit;
        logic prev;
        for (int c = 0; c < NCH; c++) snap[c] = model[c];
        @(negedge clk);
        start = 1'b1; div_cfg = DIV_W'(div);
        @(negedge clk);
        start = 1'b0;
        cyc = 0; edges = 0; prev = sclk;
        limit = 2 * (div + 1) * NB + 100;
        while (!done && cyc < limit) begin
            if (sclk && !prev) begin
                if (edges < NB) gotv[edges] = mosi;
                edges++;
            end
            prev = sclk;
            if (mid_start && cyc == 40) start = 1'b1;
            if (mid_start && cyc == 41) start = 1'b0;
            if (mid_wr && cyc == 60) begin
                wr_en = 1'b1; wr_idx = IDX_W'(mid_idx); wr_data = mid_data;
            end
            if (mid_wr && cyc == 61) begin
                wr_en = 1'b0;
                if (mid_idx < NCH) model[mid_idx] = mid_data;
            end
            @(negedge clk);
            cyc++;
        end
        check(edges == NB, {req, " R2 sclk rising edges"}, edges, NB);
        check(cyc == 2 * (div + 1) * NB, {req, " R6 start-to-done cycles"}, cyc, 2 * (div + 1) * NB);
        bad = 0;
        for (int k = 0; k < NB; k++) begin
            if (gotv[k] !== snap[NCH - 1 - k / 12][11 - k % 12]) bad++;
        end
        check(bad == 0, {req, " R3 mismatched frame bits"}, bad, 0);
        @(negedge clk);
        check(!done && !busy, {req, " R7 done one cycle, idle after"}, {done, busy}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) model[c] = '0;
        repeat (4) @(negedge clk);
        check({busy, done, sclk, mosi} == 4'b0, "R1 outputs in reset", {busy, done, sclk, mosi}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, sclk, mosi} == 4'b0, "R1 outputs after reset", {busy, done, sclk, mosi}, 0);

        // R1: the cleared store sends an all-zero frame.
        run_frame(0, "R1 zero frame", 1'b0, 1'b0, 0, '0);

        // R3: index-derived pattern on every channel.
        for (int c = 0; c < NCH; c++) write_ch(c, 12'((c * 157 + 12'h5A3) & 12'hFFF));
        run_frame(0, "R3 index pattern", 1'b0, 1'b0, 0, '0);

        // R4: invert one channel at a time; neighbours sharing a byte must survive.
        for (int c = 0; c < NCH; c++) begin
            write_ch(c, ~model[c]);
            run_frame(0, (c % 2 == 1) ? "R4 odd channel" : "R4 even channel", 1'b0, 1'b0, 0, '0);
        end

        // R5: indices at and beyond the channel count change nothing.
        for (int c = NCH; c < (1 << IDX_W); c++) write_ch(c, 12'hABC);
        run_frame(0, "R5 out-of-range writes", 1'b0, 1'b0, 0, '0);

        // R6: divider settings give the right half period and no byte gaps.
        run_frame(1, "R6 div 1", 1'b0, 1'b0, 0, '0);
        run_frame(3, "R6 div 3", 1'b0, 1'b0, 0, '0);
        run_frame(5, "R6 div 5", 1'b0, 1'b0, 0, '0);

        // R8: a second start during the frame neither restarts nor stretches it.
        run_frame(0, "R8 start while busy", 1'b1, 1'b0, 0, '0);

        // R9: a write to an already sent channel and one to a pending channel.
        run_frame(0, "R9 write sent channel", 1'b0, 1'b1, NCH - 1, 12'h3C5);
        run_frame(0, "R9 next frame carries it", 1'b0, 1'b0, 0, '0);
        run_frame(0, "R9 write pending channel", 1'b0, 1'b1, 0, 12'hE17);
        run_frame(1, "R9 next frame carries it", 1'b0, 1'b0, 0, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule